// File: doc/BRIEF.md
# Multiple-Register Word Transfer Sequencer

This block steps through a block transfer between a register file and memory. A request carries a register-selection mask, a base address, a direction (ascending or descending addresses), a choice of indexing before or after the access, a flag that asks for the base to be updated, and a load/store choice. The sequencer then presents one word access per selected register. Each access gives the register number and its word address, and accesses move forward one per cycle whenever memory reports ready.

The register with the smallest number always takes the smallest address, whatever the direction. For example, base 1000, ascending, indexing after, and registers 0, 1, 6 and 7 selected produce addresses 1000, 1004, 1008 and 1012 in that order. Once the last access is accepted, the block pulses a completion flag. In the same cycle it presents the updated base value, with a valid flag when base update was requested. The instruction decoder and the register file sit outside this block.

Top module: `blkxfer_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `rd_stb_o`, `wr_stb_o`, `done_o` and `wb_valid_o` are all low.
- R2: Each bit set in the captured mask gives exactly one access, in ascending register number. `reg_idx_o` is the bit position of that register.
- R3: Successive accesses of a transfer use consecutive word addresses, each 4 greater than the one before.
- R4: The first address, where n is the number of set mask bits, is:
  - ascending, index before: base+4
  - ascending, index after: base
  - descending, index before: base−4n
  - descending, index after: base−4n+4
- R5: While an access is presented and `mem_rdy_i` is low, the same register number and address stay on the outputs in the next cycle.
- R6: With `mem_rdy_i` held high, the first access appears in the cycle after `start_i` and one access completes per cycle. `done_o` therefore appears n+1 cycles after the start cycle.
- R7: `done_o` is a one-cycle pulse in the cycle after the final access is accepted, and never coincides with a strobe. With it, `wb_base_o` equals base+4n for ascending transfers and base−4n for descending ones.
- R8: `wb_valid_o` is high exactly when `done_o` is high and base update was requested.
- R9: An empty mask causes no access. `done_o` pulses in the cycle after `start_i`, and `wb_base_o` equals the base.
- R10: `start_i` and the request inputs are ignored while `busy_o` is high. The transfer in progress keeps its registers, addresses and final base.
- R11: During an access exactly one strobe is high. `rd_stb_o` is high for a load (`is_load_i`=1 at start) and `wr_stb_o` for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a transfer (taken only when idle) |
| mask_i | input | 16 | Register-selection mask, bit i = register i |
| base_i | input | 32 | Base address |
| dir_up_i | input | 1 | 1 = ascending addresses, 0 = descending |
| pre_idx_i | input | 1 | 1 = index before access, 0 = index after |
| wb_en_i | input | 1 | Request base update at completion |
| is_load_i | input | 1 | 1 = load, 0 = store |
| mem_rdy_i | input | 1 | Memory accepts the presented access |
| busy_o | output | 1 | Transfer in progress |
| rd_stb_o | output | 1 | Load access presented |
| wr_stb_o | output | 1 | Store access presented |
| reg_idx_o | output | 4 | Register number of the presented access |
| addr_o | output | 32 | Word address of the presented access |
| done_o | output | 1 | Transfer complete pulse |
| wb_valid_o | output | 1 | Base update value is to be written |
| wb_base_o | output | 32 | Updated base value |

## Verification
The known four-register example on an ascending, index-after transfer pins the ordering and the address step. A fixed sparse mask run under all four direction and indexing combinations separates the four start-address rules and the two final-base rules. Empty, single-top-bit and full masks probe the mask edges, and a descending transfer from base 0 checks address wraparound. Random masks, bases and modes under random ready stalls tell holding (R5) apart from advancing, and a run that pulses start mid-transfer shows that new requests cannot disturb the transfer in progress.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int DEF_NREG   = 16;
    localparam int DEF_AW     = 32;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic up;
        logic pre;
        logic wb;
        logic load;
    } xfer_mode_t;

endpackage

// File: rtl/blkxfer_span.sv
module blkxfer_span #(
    parameter int NREG   = blkxfer_pkg::DEF_NREG,
    parameter int AW     = blkxfer_pkg::DEF_AW,
    parameter int WBYTES = blkxfer_pkg::WORD_BYTES
) (
    input  logic [NREG-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic            up_i,
    input  logic            pre_i,
    output logic [AW-1:0]   first_addr_o,
    output logic [AW-1:0]   final_base_o
);
    localparam int CNTW = $clog2(NREG + 1);

    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   span;
    logic [AW-1:0]   step;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNTW'(mask_i[i]);
        end
    end

    assign step = AW'(WBYTES);
    assign span = AW'(cnt) * step;

    always_comb begin
        if (up_i) begin
            first_addr_o = pre_i ? (base_i + step) : base_i;
            final_base_o = base_i + span;
        end else begin
            first_addr_o = pre_i ? (base_i - span) : (base_i - span + step);
            final_base_o = base_i - span;
        end
    end
endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
    parameter int NREG = blkxfer_pkg::DEF_NREG,
    parameter int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask_i,
    output logic [IDXW-1:0] idx_o,
    output logic [NREG-1:0] rest_o,
    output logic            last_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IDXW'(i);
        end
    end

    assign rest_o = mask_i & (mask_i - NREG'(1));
    assign last_o = (rest_o == '0);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
    parameter int NREG = blkxfer_pkg::DEF_NREG,
    parameter int AW   = blkxfer_pkg::DEF_AW,
    parameter int IDXW = $clog2(NREG)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            start_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic            dir_up_i,
    input  logic            pre_idx_i,
    input  logic            wb_en_i,
    input  logic            is_load_i,
    input  logic            mem_rdy_i,
    output logic            busy_o,
    output logic            rd_stb_o,
    output logic            wr_stb_o,
    output logic [IDXW-1:0] reg_idx_o,
    output logic [AW-1:0]   addr_o,
    output logic            done_o,
    output logic            wb_valid_o,
    output logic [AW-1:0]   wb_base_o
);
    import blkxfer_pkg::*;

    seq_state_e      state_q;
    xfer_mode_t      mode_q;
    xfer_mode_t      mode_in;
    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   fin_q;

    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [NREG-1:0] rest;
    logic            last;
    logic            running;

    assign mode_in = '{up: dir_up_i, pre: pre_idx_i, wb: wb_en_i, load: is_load_i};

    blkxfer_span #(.NREG(NREG), .AW(AW), .WBYTES(WORD_BYTES)) u_span (
        .mask_i       (mask_i),
        .base_i       (base_i),
        .up_i         (dir_up_i),
        .pre_i        (pre_idx_i),
        .first_addr_o (first_addr),
        .final_base_o (final_base)
    );

    blkxfer_pick #(.NREG(NREG), .IDXW(IDXW)) u_pick (
        .mask_i (rem_q),
        .idx_o  (reg_idx_o),
        .rest_o (rest),
        .last_o (last)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            rem_q   <= '0;
            addr_q  <= '0;
            fin_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= mode_in;
                        rem_q   <= mask_i;
                        addr_q  <= first_addr;
                        fin_q   <= final_base;
                        state_q <= (mask_i == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (mem_rdy_i) begin
                        rem_q  <= rest;
                        addr_q <= addr_q + AW'(WORD_BYTES);
                        if (last) state_q <= ST_FIN;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign running    = (state_q == ST_RUN);
    assign busy_o     = (state_q != ST_IDLE);
    assign rd_stb_o   = running &&  mode_q.load;
    assign wr_stb_o   = running && !mode_q.load;
    assign addr_o     = addr_q;
    assign done_o     = (state_q == ST_FIN);
    assign wb_valid_o = done_o && mode_q.wb;
    assign wb_base_o  = fin_q;
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
    parameter int NREG = blkxfer_pkg::DEF_NREG,
    parameter int AW   = blkxfer_pkg::DEF_AW,
    parameter int IDXW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic            mem_rdy,
    input logic [IDXW-1:0] reg_idx,
    input logic [AW-1:0]   addr,
    input logic            done,
    input logic            wb_valid
);
    logic req;
    assign req = rd_stb || wr_stb;

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (req && !mem_rdy) |=> (req && $stable(reg_idx) && $stable(addr)));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (req && mem_rdy) |=> (!req || addr == $past(addr) + AW'(blkxfer_pkg::WORD_BYTES)));

    a_r2_idx_ascend: assert property (@(posedge clk) disable iff (rst)
        (req && mem_rdy) |=> (!req || reg_idx > $past(reg_idx)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_no_strobe: assert property (@(posedge clk) disable iff (rst)
        done |-> !req);

    a_r8_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        req |-> !(rd_stb && wr_stb));
endmodule

bind blkxfer_seq blkxfer_chk #(.NREG(NREG), .AW(AW), .IDXW(IDXW)) u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .rd_stb   (rd_stb_o),
    .wr_stb   (wr_stb_o),
    .mem_rdy  (mem_rdy_i),
    .reg_idx  (reg_idx_o),
    .addr     (addr_o),
    .done     (done_o),
    .wb_valid (wb_valid_o)
);

// File: tb/test_blkxfer_seq.sv
module test_blkxfer_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [15:0] mask_i;
    logic [31:0] base_i;
    logic        dir_up_i, pre_idx_i, wb_en_i, is_load_i, mem_rdy_i;
    logic        busy_o, rd_stb_o, wr_stb_o, done_o, wb_valid_o;
    logic [3:0]  reg_idx_o;
    logic [31:0] addr_o, wb_base_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blkxfer_seq i_blkxfer_seq (
        .clk_i(clk), .rst_i(rst), .start_i(start_i), .mask_i(mask_i),
        .base_i(base_i), .dir_up_i(dir_up_i), .pre_idx_i(pre_idx_i),
        .wb_en_i(wb_en_i), .is_load_i(is_load_i), .mem_rdy_i(mem_rdy_i),
        .busy_o(busy_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
        .reg_idx_o(reg_idx_o), .addr_o(addr_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int ones(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic int nth_set(input logic [15:0] m, input int k);
        int seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    function automatic logic [31:0] exp_first(input logic [15:0] m, input logic [31:0] b,
                                              input bit up, input bit pre);
        logic [31:0] span = 32'(4 * ones(m));
        if (up) return pre ? b + 32'd4 : b;
        return pre ? b - span : b - span + 32'd4;
    endfunction

    function automatic logic [31:0] exp_final(input logic [15:0] m, input logic [31:0] b,
                                              input bit up);
        logic [31:0] span = 32'(4 * ones(m));
        return up ? b + span : b - span;
    endfunction

    task automatic xfer(input logic [15:0] m, input logic [31:0] b, input bit up,
                        input bit pre, input bit wb, input bit ld,
                        input int stall_pct, input bit poke);
        int n = ones(m);
        int k = 0;
        int cyc = 1;
        bit prev_stall = 1'b0;
        logic [31:0] first = exp_first(m, b, up, pre);
        logic [31:0] fin = exp_final(m, b, up);
        @(negedge clk);
        start_i = 1'b1; mask_i = m; base_i = b;
        dir_up_i = up; pre_idx_i = pre; wb_en_i = wb; is_load_i = ld;
        mem_rdy_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        mask_i = 16'($urandom); base_i = $urandom;
        dir_up_i = ~up; pre_idx_i = ~pre; wb_en_i = ~wb; is_load_i = ~ld;
        while (cyc < 400) begin
            mem_rdy_i = (int'($urandom_range(99, 0)) >= stall_pct);
            if (poke && cyc == 2) begin
                start_i = 1'b1; mask_i = ~m; base_i = b ^ 32'h0000_0f00;
            end
            #1;
            if (done_o) begin
                chk(k == n, "R2", "access count", 32'(k), 32'(n));
                chk(wb_base_o == fin, "R7", "final base", wb_base_o, fin);
                chk(wb_valid_o == wb, "R8", "wb valid", 32'(wb_valid_o), 32'(wb));
                chk(!rd_stb_o && !wr_stb_o, "R7", "strobe with done", 32'(rd_stb_o | wr_stb_o), 32'd0);
                if (n == 0) chk(cyc == 1, "R9", "empty done cycle", 32'(cyc), 32'd1);
                if (stall_pct == 0) chk(cyc == n + 1, "R6", "done cycle", 32'(cyc), 32'(n + 1));
                if (poke) chk(k == n, "R10", "start during busy", 32'(k), 32'(n));
                break;
            end
            if (k >= n) begin
                chk(1'b0, (n == 0) ? "R9" : "R2", "extra access or missing done",
                    32'(rd_stb_o | wr_stb_o), 32'd0);
                break;
            end
            chk(rd_stb_o == ld && wr_stb_o == !ld, "R11", "strobes",
                {30'd0, rd_stb_o, wr_stb_o}, {30'd0, ld, !ld});
            chk(32'(reg_idx_o) == 32'(nth_set(m, k)), prev_stall ? "R5" : "R2", "register",
                32'(reg_idx_o), 32'(nth_set(m, k)));
            chk(addr_o == first + 32'(4 * k), (k == 0) ? "R4" : (prev_stall ? "R5" : "R3"),
                "address", addr_o, first + 32'(4 * k));
            if (poke) chk(busy_o == 1'b1, "R10", "busy", 32'(busy_o), 32'd1);
            prev_stall = !mem_rdy_i;
            if (mem_rdy_i) k++;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        if (cyc >= 400) chk(1'b0, "R7", "done never seen", 32'(cyc), 32'(n + 1));
        @(negedge clk);
        chk(!busy_o && !done_o, "R7", "return to idle", {30'd0, busy_o, done_o}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start_i = 1'b0; mask_i = '0; base_i = '0;
        dir_up_i = 1'b0; pre_idx_i = 1'b0; wb_en_i = 1'b0; is_load_i = 1'b0; mem_rdy_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy_o && !rd_stb_o && !wr_stb_o && !done_o && !wb_valid_o, "R1", "reset outputs",
            {27'd0, busy_o, rd_stb_o, wr_stb_o, done_o, wb_valid_o}, 32'd0);
        rst = 1'b0;
        // R2 R3 R4: worked example, registers 0,1,6,7 from base 1000
        xfer(16'h00C3, 32'd1000, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        // R4 R7: all four indexing combinations on one mask
        for (int md = 0; md < 4; md++)
            xfer(16'h8421, 32'h0000_0100, md[1], md[0], 1'b1, md[0], 0, 1'b0);
        // R9: empty mask, with and without update
        xfer(16'h0000, 32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0);
        xfer(16'h0000, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0);
        // Edges: top register alone, full list, wraparound below zero
        xfer(16'h8000, 32'h0000_0040, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        xfer(16'hFFFF, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
        xfer(16'h0505, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        // R10: start pulsed in the middle of a transfer
        xfer(16'h0F0F, 32'h0000_3000, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1);
        xfer(16'h1111, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b0, 30, 1'b1);
        // R5: heavy stalls
        xfer(16'h00FF, 32'h0000_4000, 1'b1, 1'b0, 1'b1, 1'b1, 70, 1'b0);
        for (int t = 0; t < 60; t++) begin
            logic [15:0] m = 16'($urandom);
            if (t % 10 == 3) m = 16'h0000;
            if (t % 10 == 7) m = 16'hFFFF;
            xfer(m, {$urandom} & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), (t % 3 == 0) ? 0 : 40, 1'(t % 5 == 4));
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule